// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked on-chip bus and an external 64K x 16 asynchronous static RAM. A requester raises a request with a direction, a 16-bit word address, write data and one enable per byte lane. The controller latches that request and plays out a read or write cycle on the memory pins. It then pulses an acknowledge for one cycle. For reads, the returned word is valid at the same time as the acknowledge.

Each phase of a cycle lasts a whole number of clock cycles. That number comes from a minimum time in nanoseconds and the clock period, both of which are parameters. A write starts with output enable high and the controller's own drivers off, and waits out the interval during which the memory may still drive the bus. Only then does it pull write enable low and drive data, for the width of the write pulse. A read holds chip enable and output enable low for the read cycle time and samples the bus on the edge that ends that window.

Between cycles every control pin is high, so the memory sits in standby.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever no cycle is in progress, the memory control pins are all high, the data drivers are off and the acknowledge is low.
- R2: Every phase length is ceil(minimum time / clock period) cycles and is never less than one cycle. With the default 8 ns clock this gives a 3-cycle turnaround, a 5-cycle write pulse, a 1-cycle write recovery and a 7-cycle read window.
- R3: A write first holds chip enable and the byte enables low, with output enable and write enable high and the drivers off, for the turnaround count. Only after that does write enable fall.
- R4: Write enable stays low for the pulse count, which is the largest of the pulse-width, enable-to-end and data-setup figures. The drivers present the latched write data for the whole pulse.
- R5: The acknowledge for a write arrives turnaround + pulse + recovery cycles after the edge that accepts the request. Recovery is max(1, write cycle count − turnaround − pulse).
- R6: A read holds chip enable and output enable low, with write enable high, for the read count. The acknowledge follows that many cycles after acceptance, and the read data is valid while the acknowledge is high.
- R7: Byte-enable bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. During a cycle each active-low byte-enable pin is the inverse of its latched bit. A write changes only the enabled lanes, and a read returns zero in a disabled lane.
- R8: The acknowledge is a one-cycle pulse. A request is accepted only when no cycle is in progress. Changes to the address, data, direction or lanes after acceptance have no effect on the cycle under way.
- R9: The data drivers are enabled only while output enable is high and write enable is low.
- R10: The memory address stays constant for as long as chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, sampled only while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with ack |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_dq_o | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
With the default 8 ns clock, the acknowledge for a write is due 9 cycles after the accepting edge and the acknowledge for a read is due 7 cycles after it. Read data is checked in that same acknowledge cycle. Each request is queued with its accepting cycle number, and a monitor measures the latency when the acknowledge appears. A pin monitor sampling on falling edges measures the turnaround run before write enable falls (3 cycles), the write-enable run (5 cycles) and the output-enable run (7 cycles). It also counts every cycle in which the driver, lane or address rules are broken.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSET, PH_WPUL, PH_WREC, PH_READ, PH_DONE
  } phase_e;

  // whole cycles covering t_ns, at least one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int n;
    n = (t_ns + clk_ns - 1) / clk_ns;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CW    = 4,
  parameter int N_HZ  = 3,
  parameter int N_PWE = 5,
  parameter int N_REC = 1,
  parameter int N_RD  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          last,
  output phase_e        phase,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          cap
);
  phase_e nxt;

  always_comb begin
    nxt      = phase;
    load     = 1'b0;
    load_val = '0;
    case (phase)
      PH_IDLE: if (req) begin
        load = 1'b1;
        if (req_we) begin nxt = PH_WSET; load_val = CW'(N_HZ); end
        else        begin nxt = PH_READ; load_val = CW'(N_RD); end
      end
      PH_WSET: if (last) begin nxt = PH_WPUL; load = 1'b1; load_val = CW'(N_PWE); end
      PH_WPUL: if (last) begin nxt = PH_WREC; load = 1'b1; load_val = CW'(N_REC); end
      PH_WREC: if (last) nxt = PH_DONE;
      PH_READ: if (last) nxt = PH_DONE;
      PH_DONE: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign accept = (phase == PH_IDLE) && req;
  assign cap    = (phase == PH_READ) && last;
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             cap,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    mem_dq_i,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    lat_wdata,
  output logic [LANES-1:0] lat_be,
  output logic [DW-1:0]    rsp_rdata
);
  localparam int LW = DW / LANES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else if (accept) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_be    <= req_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rsp_rdata[g*LW +: LW] <= '0;
      else if (cap) rsp_rdata[g*LW +: LW] <= lat_be[g] ? mem_dq_i[g*LW +: LW] : '0;
    end
  end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sramc_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 8,
  parameter int T_WC_NS  = 55,
  parameter int T_PWE_NS = 40,
  parameter int T_SCE_NS = 40,
  parameter int T_SD_NS  = 25,
  parameter int T_HZ_NS  = 20,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             ack,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_be_n,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_i
);
  localparam int N_HZ  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int N_PWE = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SCE_NS, CLK_NS)),
                              ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int N_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int N_REC = imax(1, N_WC - N_HZ - N_PWE);
  localparam int N_RD  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                              ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int N_MAX = imax(imax(N_HZ, N_PWE), imax(N_REC, N_RD));
  localparam int CW    = $clog2(N_MAX + 1);

  phase_e           phase;
  logic             load, last, accept, cap, in_access;
  logic [CW-1:0]    load_val;
  logic [LANES-1:0] lat_be;
  logic [DW-1:0]    lat_wdata;

  sramc_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  sramc_seq #(.CW(CW), .N_HZ(N_HZ), .N_PWE(N_PWE), .N_REC(N_REC), .N_RD(N_RD)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .last(last),
    .phase(phase), .load(load), .load_val(load_val), .accept(accept), .cap(cap)
  );

  sramc_lanes #(.AW(AW), .DW(DW), .LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cap(cap),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .mem_dq_i(mem_dq_i),
    .lat_addr(mem_addr), .lat_wdata(lat_wdata), .lat_be(lat_be), .rsp_rdata(rsp_rdata)
  );

  assign in_access = (phase == PH_WSET) || (phase == PH_WPUL) ||
                     (phase == PH_WREC) || (phase == PH_READ);
  assign mem_ce_n  = !in_access;
  assign mem_oe_n  = (phase != PH_READ);
  assign mem_we_n  = (phase != PH_WPUL);
  assign mem_be_n  = in_access ? ~lat_be : '1;
  assign mem_dq_oe = (phase == PH_WPUL);
  assign mem_dq_o  = lat_wdata;
  assign ack       = (phase == PH_DONE);
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int AW    = 16,
  parameter int LANES = 2,
  parameter int N_HZ  = 3,
  parameter int N_PWE = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             ack,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ce_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_be_n,
  input logic             mem_dq_oe
);
  logic [7:0] hz_run, wl_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_run <= '0;
      wl_run <= '0;
    end else begin
      if (mem_ce_n || !mem_oe_n) hz_run <= '0;
      else if (hz_run != 8'hFF)  hz_run <= hz_run + 1'b1;
      if (mem_we_n)              wl_run <= '0;
      else if (wl_run != 8'hFF)  wl_run <= wl_run + 1'b1;
    end
  end

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && (mem_be_n == '1) && !mem_dq_oe));

  p_turnaround_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (hz_run >= 8'(N_HZ)));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_run == 8'(N_PWE)));

  p_read_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (mem_ce_n && !ack));

  p_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .AW(AW), .LANES(LANES), .N_HZ(N_HZ), .N_PWE(N_PWE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .ack(ack), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_async_ctl.sv
`timescale 1ns/1ps
module sim_sram_async_ctl;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ack, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0]  mem_be_n;

  always #4 clk = ~clk;

  sram_async_ctl #(.CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected phase lengths from the requirements, counted by stepping
  function automatic int steps(input int t);
    int n = 0;
    while (n * CLK_NS < t) n++;
    if (n == 0) n = 1;
    return n;
  endfunction
  int e_hz, e_pwe, e_wr, e_rd;

  // memory model (low 256 words)
  logic [15:0] model [256];
  logic [15:0] shadow [256];

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
        mem_dq_i[l*8 +: 8] = model[mem_addr[7:0]][l*8 +: 8];
      else
        mem_dq_i[l*8 +: 8] = 8'hEE;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queue
  typedef struct { bit rd; logic [15:0] exp; int start; int lat; } item_t;
  item_t sbq[$];

  // pin monitor state
  logic [15:0] cur_addr, cur_wd;
  logic [1:0]  cur_be;
  int srun = 0, wrun = 0, orun = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int v_drive = 0, v_lane = 0, v_data = 0, v_addr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // model write while pulse active
      if (!mem_ce_n && !mem_we_n && mem_dq_oe)
        for (int l = 0; l < 2; l++)
          if (!mem_be_n[l]) model[mem_addr[7:0]][l*8 +: 8] = mem_dq_o[l*8 +: 8];
      if (mem_dq_oe && (!mem_oe_n || mem_we_n)) v_drive++;
      if (!mem_ce_n && mem_be_n != ~cur_be) v_lane++;
      if (!mem_ce_n && mem_addr != cur_addr) v_addr++;
      if (!mem_we_n && (mem_dq_o != cur_wd || !mem_dq_oe)) v_data++;
      // R3 turnaround run before write enable falls
      if (!mem_we_n && prev_we) chk(srun == e_hz, "R3 turnaround cycles", srun, e_hz);
      if (mem_ce_n) srun = 0;
      else if (mem_oe_n && mem_we_n && !mem_dq_oe) srun++;
      // R4 pulse width
      if (!mem_we_n) wrun++;
      else if (!prev_we) begin chk(wrun == e_pwe, "R4 pulse cycles", wrun, e_pwe); wrun = 0; end
      // R6 read window
      if (!mem_oe_n) orun++;
      else if (!prev_oe) begin chk(orun == e_rd, "R6 read window cycles", orun, e_rd); orun = 0; end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
      // scoreboard monitor
      if (ack) begin
        if (sbq.size() == 0) chk(0, "R8 unexpected ack", 1, 0);
        else begin
          item_t it;
          it = sbq.pop_front();
          chk(cyc - it.start == it.lat, it.rd ? "R6 R2 read ack latency" : "R5 R2 write ack latency",
              cyc - it.start, it.lat);
          if (it.rd) chk(rsp_rdata == it.exp, "R6 R7 read data", rsp_rdata, it.exp);
        end
      end
    end
  end

  task automatic do_op(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    item_t it;
    logic [15:0] e = '0;
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      if (w && be[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
      if (!w && be[l]) e[l*8 +: 8] = shadow[a[7:0]][l*8 +: 8];
    end
    it.rd = !w; it.exp = e; it.start = cyc + 1; it.lat = w ? e_wr : e_rd;
    sbq.push_back(it);
    cur_addr = a; cur_wd = d; cur_be = be;
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    // R8: inputs changed after acceptance must be ignored
    req_we = !w; req_addr = ~a; req_wdata = ~d; req_be = ~be;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    // R8: ack gone on the next cycle
    @(negedge clk);
    chk(!ack, "R8 ack single cycle", ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int e_wc;
    for (int i = 0; i < 256; i++) begin model[i] = '0; shadow[i] = '0; end
    e_hz  = steps(20);
    e_pwe = steps(40) > steps(25) ? steps(40) : steps(25);
    e_wc  = steps(55);
    e_wr  = e_hz + e_pwe + ((e_wc - e_hz - e_pwe) > 1 ? (e_wc - e_hz - e_pwe) : 1);
    e_rd  = steps(55);
    cur_addr = '0; cur_wd = '0; cur_be = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 controls in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(mem_be_n == 2'b11 && !mem_dq_oe && !ack, "R1 lanes/drivers/ack in reset",
        {mem_be_n, mem_dq_oe, ack}, 12);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset", mem_ce_n, 1);

    do_op(1, 16'h0010, 16'hA5C3, 2'b11);
    do_op(0, 16'h0010, 16'h0000, 2'b11);
    do_op(1, 16'h0010, 16'h1234, 2'b01);   // R7 low lane only
    do_op(0, 16'h0010, 16'h0000, 2'b11);
    do_op(1, 16'h0010, 16'h9900, 2'b10);   // R7 high lane only
    do_op(0, 16'h0010, 16'h0000, 2'b01);
    do_op(0, 16'h0010, 16'h0000, 2'b10);
    do_op(1, 16'h0010, 16'hFFFF, 2'b00);   // R7 no lane: nothing written
    do_op(0, 16'h0010, 16'h0000, 2'b11);
    do_op(0, 16'h0010, 16'h0000, 2'b00);   // R7 no lane read gives zero
    for (int i = 0; i < 8; i++)
      do_op(1, 16'(i * 37 + 16'h0300), 16'(16'h1111 * (i + 1) ^ 16'h5A00), 2'b11);
    for (int i = 0; i < 8; i++)
      do_op(0, 16'(i * 37 + 16'h0300), 16'h0000, 2'b11);
    do_op(1, 16'hFFFF, 16'h0F0F, 2'b11);
    do_op(0, 16'h00FF, 16'h0000, 2'b11);

    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R1 standby between cycles", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(sbq.size() == 0, "R8 every request acknowledged", sbq.size(), 0);
    chk(v_drive == 0, "R9 driver enabled outside pulse", v_drive, 0);
    chk(v_lane == 0, "R7 lane pins differ from request", v_lane, 0);
    chk(v_data == 0, "R4 data not held during pulse", v_data, 0);
    chk(v_addr == 0, "R10 address moved during access", v_addr, 0);
    finish_run();
  end
endmodule